// File: doc/BRIEF.md
# BCD 24-Hour Time-of-Day Clock

This block keeps the time of day as six BCD digits (hours, minutes and seconds) and drives one active-low seven-segment pattern for each digit. A divider turns the system clock into a single-cycle enable pulse once per second. The divider defaults to 50,000,000 cycles, which gives one pulse per second from a 50 MHz clock, and can be set much shorter for simulation. The seconds feed the minutes, the minutes feed the hours, and the hours wrap after 23.

A 16-bit preset field holds the hour pair in its upper byte and the minute pair in its lower byte. While the load strobe is high, hours and minutes take the preset, seconds are cleared and the divider restarts. A preset that is not a legal time is replaced by the largest legal value. The raw BCD digits are also brought out so the count can be read without decoding the segment patterns.

Top module: `clk24_tod_clock`

## Requirements
- R1: A low `rst_n` at a rising clock edge sets the time to 00:00:00 and restarts the divider (reset is synchronous).
- R2: The time advances by one second every TICK_DIV cycles: k edges after reset or load, the seconds count has advanced by floor(k/TICK_DIV).
- R3: Seconds count 00 to 59. An advance from 59 gives 00 and increments the minutes.
- R4: Minutes count 00 to 59. A wrap from 59 to 00 increments the hours.
- R5: Hours count 00 to 23. The advance after 23:59:59 gives 00:00:00.
- R6: At an edge where `load` is high, hours take `preset_sw[15:8]` (tens digit in [15:12]), minutes take `preset_sw[7:0]` (tens digit in [7:4]), seconds become 00 and the divider restarts. Load takes priority over counting.
- R7: A preset pair is illegal if either nibble is above 9 or its value exceeds the limit. An illegal hour preset loads as 23 and an illegal minute preset loads as 59.
- R8: Each segment output is ordered g..a (bit 6 = g, bit 0 = a) and is active low. Digits 0 through 9 map to 1000000, 1111001, 0100100, 0110000, 0011001, 0010010, 0000010, 1111000, 0000000, 0010000.
- R9: `seg_hr_t`/`seg_hr_o` show the hour tens and ones digits, `seg_mn_t`/`seg_mn_o` the minute digits and `seg_sc_t`/`seg_sc_o` the second digits. `bcd_*` carry each pair with the tens digit in bits [7:4].
- R10: While `load` is low, changes on `preset_sw` have no effect on the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low clear |
| preset_sw | input | 16 | Hour BCD pair [15:8], minute BCD pair [7:0] |
| load | input | 1 | Apply preset and clear seconds |
| seg_hr_t | output | 7 | Hour tens pattern, active low |
| seg_hr_o | output | 7 | Hour ones pattern, active low |
| seg_mn_t | output | 7 | Minute tens pattern, active low |
| seg_mn_o | output | 7 | Minute ones pattern, active low |
| seg_sc_t | output | 7 | Second tens pattern, active low |
| seg_sc_o | output | 7 | Second ones pattern, active low |
| bcd_hr | output | 8 | Hours as BCD |
| bcd_mn | output | 8 | Minutes as BCD |
| bcd_sc | output | 8 | Seconds as BCD |

## Verification
The hardest state to reach from the ports is the full-day rollover from 23:59:59. Counting up to it from reset would take 86,400 ticks. Instead, the bench shortens the divider to four cycles, loads 23:59 (which also zeroes the seconds and restarts the divider) and then steps exactly 59 and 60 ticks, checking the time at each point. The minute-into-hour carry and the seconds wrap are reached in the same way, and the clamp cases are reached by loading out-of-range switch patterns.

// File: rtl/clk24_pkg.sv
// Shared types and helpers for the 24-hour clock.
// Assumes BCD pairs are packed as tens in the upper nibble.
package clk24_pkg;

    typedef logic [3:0] bcd_t;

    typedef struct packed {
        bcd_t tens;
        bcd_t ones;
    } bcd_pair_t;

    // Replace an illegal BCD pair with the largest legal value below limit+1.
    function automatic bcd_pair_t clamp_pair(bcd_pair_t v, int limit);
        bcd_pair_t r;
        if (v.tens > 4'd9 || v.ones > 4'd9 ||
            (int'(v.tens) * 10 + int'(v.ones)) > limit) begin
            r.tens = 4'(limit / 10);
            r.ones = 4'(limit % 10);
        end else begin
            r = v;
        end
        return r;
    endfunction

endpackage

// File: rtl/clk24_tick_gen.sv
// One-second enable generator: emits a single-cycle pulse every DIV cycles.
// Assumes restart and rst_n are synchronous; restart zeroes the phase.
module clk24_tick_gen #(
    parameter int unsigned DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase;

    // Phase counter: wraps at DIV-1, cleared by reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign tick = (phase == LAST);

    generate
        if (DIV > 1) begin : g_pulse_chk
            // R2: the enable never lasts more than one cycle
            a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
                tick && !restart |=> !tick);
            // R6: restart delays the next pulse
            a_r6_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                restart |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/clk24_bcd_pair.sv
// Two-digit BCD counter that wraps from LIMIT to 00 when enabled.
// Assumes load_val is already legal (clamped by the caller); load wins over en.
module clk24_bcd_pair
    import clk24_pkg::*;
#(
    parameter int LIMIT = 59
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      load,
    input  bcd_pair_t load_val,
    output bcd_pair_t value,
    output logic      at_limit
);
    localparam bcd_t LIM_T = 4'(LIMIT / 10);
    localparam bcd_t LIM_O = 4'(LIMIT % 10);

    // Count register: reset, load, wrap at limit, or decimal increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (load) begin
            value <= load_val;
        end else if (en) begin
            if (at_limit) begin
                value <= '0;
            end else if (value.ones == 4'd9) begin
                value.ones <= 4'd0;
                value.tens <= value.tens + 4'd1;
            end else begin
                value.ones <= value.ones + 4'd1;
            end
        end
    end

    assign at_limit = (value.tens == LIM_T) && (value.ones == LIM_O);

    // R3, R4, R5: the pair always holds a legal decimal value up to LIMIT
    a_r3_pair_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        value.ones <= 4'd9 && (int'(value.tens) * 10 + int'(value.ones)) <= LIMIT);
    // R3, R4, R5: an enabled advance at the limit returns to 00
    a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        en && !load && at_limit |=> value == '0);
    // R10: without enable or load the pair does not move
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en && !load |=> $stable(value));
    // R6: load captures the offered value
    a_r6_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> value == $past(load_val));

endmodule

// File: rtl/clk24_seg7.sv
// Active-low seven-segment decoder, bit order g..a.
// Assumes a BCD digit; non-decimal codes blank the display.
module clk24_seg7
    import clk24_pkg::*;
(
    input  bcd_t       digit,
    output logic [6:0] seg
);
    // Digit-to-pattern lookup.
    always_comb begin
        case (digit)
            4'd0:    seg = 7'b1000000;
            4'd1:    seg = 7'b1111001;
            4'd2:    seg = 7'b0100100;
            4'd3:    seg = 7'b0110000;
            4'd4:    seg = 7'b0011001;
            4'd5:    seg = 7'b0010010;
            4'd6:    seg = 7'b0000010;
            4'd7:    seg = 7'b1111000;
            4'd8:    seg = 7'b0000000;
            4'd9:    seg = 7'b0010000;
            default: seg = 7'b1111111;
        endcase
    end
endmodule

// File: rtl/clk24_tod_clock.sv
// 24-hour time-of-day clock: divider, chained BCD pairs and six decoders.
// Assumes rst_n and load are synchronous to clk; TICK_DIV >= 1.
module clk24_tod_clock
    import clk24_pkg::*;
#(
    parameter int unsigned TICK_DIV = 50_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] preset_sw,
    input  logic        load,
    output logic [6:0]  seg_hr_t,
    output logic [6:0]  seg_hr_o,
    output logic [6:0]  seg_mn_t,
    output logic [6:0]  seg_mn_o,
    output logic [6:0]  seg_sc_t,
    output logic [6:0]  seg_sc_o,
    output logic [7:0]  bcd_hr,
    output logic [7:0]  bcd_mn,
    output logic [7:0]  bcd_sc
);
    localparam int HR_LIMIT  = 23;
    localparam int MIN_LIMIT = 59;
    localparam int SEC_LIMIT = 59;
    localparam int NDIG      = 6;

    logic      tick;
    logic      sc_en, mn_en, hr_en;
    logic      sc_top, mn_top, hr_top;
    bcd_pair_t sc_val, mn_val, hr_val;
    bcd_pair_t hr_pre, mn_pre;
    bcd_t      digits [NDIG];
    logic [6:0] segs  [NDIG];

    clk24_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .tick    (tick)
    );

    // Carry chain: each stage advances when all lower stages wrap.
    assign sc_en = tick;
    assign mn_en = sc_en & sc_top;
    assign hr_en = mn_en & mn_top;

    // Preset conditioning: illegal pairs snap to the stage limit.
    assign hr_pre = clamp_pair(preset_sw[15:8], HR_LIMIT);
    assign mn_pre = clamp_pair(preset_sw[7:0], MIN_LIMIT);

    clk24_bcd_pair #(.LIMIT(SEC_LIMIT)) u_sec (
        .clk (clk), .rst_n (rst_n), .en (sc_en), .load (load),
        .load_val ('0), .value (sc_val), .at_limit (sc_top)
    );

    clk24_bcd_pair #(.LIMIT(MIN_LIMIT)) u_min (
        .clk (clk), .rst_n (rst_n), .en (mn_en), .load (load),
        .load_val (mn_pre), .value (mn_val), .at_limit (mn_top)
    );

    clk24_bcd_pair #(.LIMIT(HR_LIMIT)) u_hr (
        .clk (clk), .rst_n (rst_n), .en (hr_en), .load (load),
        .load_val (hr_pre), .value (hr_val), .at_limit (hr_top)
    );

    // Digit order, most significant first.
    assign digits[0] = hr_val.tens;
    assign digits[1] = hr_val.ones;
    assign digits[2] = mn_val.tens;
    assign digits[3] = mn_val.ones;
    assign digits[4] = sc_val.tens;
    assign digits[5] = sc_val.ones;

    generate
        for (genvar g = 0; g < NDIG; g++) begin : g_dec
            clk24_seg7 u_seg (.digit (digits[g]), .seg (segs[g]));
        end
    endgenerate

    assign seg_hr_t = segs[0];
    assign seg_hr_o = segs[1];
    assign seg_mn_t = segs[2];
    assign seg_mn_o = segs[3];
    assign seg_sc_t = segs[4];
    assign seg_sc_o = segs[5];
    assign bcd_hr   = hr_val;
    assign bcd_mn   = mn_val;
    assign bcd_sc   = sc_val;

    // R6: a load leaves seconds at 00
    a_r6_sec_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> bcd_sc == 8'h00);
    // R5: end of day returns to midnight
    a_r5_midnight: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !load && hr_top && mn_top && sc_top |=>
        bcd_hr == 8'h00 && bcd_mn == 8'h00 && bcd_sc == 8'h00);
    // R7: a bad hour nibble loads as 23
    a_r7_hr_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        load && (preset_sw[15:12] > 4'd2 || preset_sw[11:8] > 4'd9) |=> bcd_hr == 8'h23);
    // R7: a bad minute nibble loads as 59
    a_r7_mn_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        load && (preset_sw[7:4] > 4'd5 || preset_sw[3:0] > 4'd9) |=> bcd_mn == 8'h59);
    // R4: minutes move only on a seconds wrap or load
    a_r4_min_carry: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !(tick && sc_top) |=> $stable(bcd_mn));

endmodule

// File: tb/clk24_tod_clock_tb.sv
`timescale 1ns/1ps
module clk24_tod_clock_tb;
    localparam int unsigned DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] preset_sw = 16'h0000;
    logic        load = 1'b0;
    logic [6:0]  seg_hr_t, seg_hr_o, seg_mn_t, seg_mn_o, seg_sc_t, seg_sc_o;
    logic [7:0]  bcd_hr, bcd_mn, bcd_sc;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    clk24_tod_clock #(.TICK_DIV(DIV)) u_dut (
        .clk (clk), .rst_n (rst_n), .preset_sw (preset_sw), .load (load),
        .seg_hr_t (seg_hr_t), .seg_hr_o (seg_hr_o),
        .seg_mn_t (seg_mn_t), .seg_mn_o (seg_mn_o),
        .seg_sc_t (seg_sc_t), .seg_sc_o (seg_sc_o),
        .bcd_hr (bcd_hr), .bcd_mn (bcd_mn), .bcd_sc (bcd_sc)
    );

    // Segment patterns from R8.
    function automatic logic [6:0] seg_of(logic [3:0] d);
        case (d)
            4'd0: return 7'b1000000;
            4'd1: return 7'b1111001;
            4'd2: return 7'b0100100;
            4'd3: return 7'b0110000;
            4'd4: return 7'b0011001;
            4'd5: return 7'b0010010;
            4'd6: return 7'b0000010;
            4'd7: return 7'b1111000;
            4'd8: return 7'b0000000;
            4'd9: return 7'b0010000;
            default: return 7'b1111111;
        endcase
    endfunction

    task automatic check(string req, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%06h expected=%06h", req, act, exp);
        end
    endtask

    task automatic check_time(string req, logic [7:0] h, logic [7:0] m, logic [7:0] s);
        check(req, {bcd_hr, bcd_mn, bcd_sc}, {h, m, s});
    endtask

    task automatic check_segs(string req, logic [7:0] h, logic [7:0] m, logic [7:0] s);
        checks++;
        if ({seg_hr_t, seg_hr_o, seg_mn_t, seg_mn_o, seg_sc_t, seg_sc_o} !==
            {seg_of(h[7:4]), seg_of(h[3:0]), seg_of(m[7:4]), seg_of(m[3:0]),
             seg_of(s[7:4]), seg_of(s[3:0])}) begin
            bad++;
            $display("FAIL %s: actual=%h %h %h %h %h %h expected digits %02h:%02h:%02h",
                     req, seg_hr_t, seg_hr_o, seg_mn_t, seg_mn_o, seg_sc_t, seg_sc_o, h, m, s);
        end
    endtask

    task automatic edges(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic do_load(logic [15:0] sw);
        @(negedge clk);
        preset_sw = sw;
        load = 1'b1;
        @(negedge clk) load = 1'b0;
    endtask

    // R1, R8, R9: reset state and blank-zero patterns
    task automatic t_reset();
        do_reset();
        check_time("R1 reset", 8'h00, 8'h00, 8'h00);
        check_segs("R8 zero pattern", 8'h00, 8'h00, 8'h00);
    endtask

    // R2: one advance per DIV edges
    task automatic t_tick();
        do_reset();
        edges(DIV - 1);
        check_time("R2 before tick", 8'h00, 8'h00, 8'h00);
        edges(1);
        check_time("R2 first tick", 8'h00, 8'h00, 8'h01);
        edges(DIV * 9);
        check_time("R2 ten ticks", 8'h00, 8'h00, 8'h10);
    endtask

    // R3: seconds wrap into minutes
    task automatic t_sec_wrap();
        do_load(16'h1234);
        check_time("R6 load 12:34", 8'h12, 8'h34, 8'h00);
        edges(DIV * 59);
        check_time("R3 at 59", 8'h12, 8'h34, 8'h59);
        edges(DIV);
        check_time("R3 wrap", 8'h12, 8'h35, 8'h00);
    endtask

    // R4: minutes wrap into hours
    task automatic t_min_wrap();
        do_load(16'h0959);
        edges(DIV * 60);
        check_time("R4 carry to hour", 8'h10, 8'h00, 8'h00);
    endtask

    // R5: end of day
    task automatic t_day_wrap();
        do_load(16'h2359);
        edges(DIV * 59);
        check_time("R5 23:59:59", 8'h23, 8'h59, 8'h59);
        edges(DIV);
        check_time("R5 midnight", 8'h00, 8'h00, 8'h00);
    endtask

    // R6: load restarts the divider mid-second
    task automatic t_load_restart();
        do_reset();
        edges(DIV - 2);
        do_load(16'h0102);
        edges(DIV - 1);
        check_time("R6 divider restarted", 8'h01, 8'h02, 8'h00);
        edges(1);
        check_time("R6 tick after load", 8'h01, 8'h02, 8'h01);
    endtask

    // R7: out-of-range presets clamp
    task automatic t_clamp();
        do_load(16'h3560);
        check_time("R7 clamp both", 8'h23, 8'h59, 8'h00);
        do_load(16'h2A5F);
        check_time("R7 bad ones nibbles", 8'h23, 8'h59, 8'h00);
        do_load(16'h2400);
        check_time("R7 hour 24", 8'h23, 8'h00, 8'h00);
        do_load(16'h1958);
        check_time("R7 legal passes", 8'h19, 8'h58, 8'h00);
    endtask

    // R8, R9: digit mapping on a mixed time
    task automatic t_segs();
        do_load(16'h1958);
        edges(DIV * 37);
        check_time("R9 bcd 19:58:37", 8'h19, 8'h58, 8'h37);
        check_segs("R8 R9 segments 19:58:37", 8'h19, 8'h58, 8'h37);
        do_load(16'h2046);
        check_segs("R8 R9 segments 20:46:00", 8'h20, 8'h46, 8'h00);
    endtask

    // R10: switches ignored without load; R1 reset mid-run
    task automatic t_ignore();
        do_load(16'h0815);
        @(negedge clk) preset_sw = 16'h2233;
        edges(DIV * 3 - 1);
        check_time("R10 switches ignored", 8'h08, 8'h15, 8'h03);
        do_reset();
        check_time("R1 reset mid-run", 8'h00, 8'h00, 8'h00);
    endtask

    initial begin
        t_reset();
        t_tick();
        t_sec_wrap();
        t_min_wrap();
        t_day_wrap();
        t_load_restart();
        t_clamp();
        t_segs();
        t_ignore();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule